// File: doc/BRIEF.md
# Inline Event CRC Checker with Two-Way Merge

This block sits in the middle of a stream that carries data in events. It has several input channels and one output. The channel named by a select register is passed to the output unchanged and with no added cycles. Every input channel is checked, whether it is forwarded or not. Each event is a run of 32-bit words. The first word is marked by a start flag and the last word by an end flag. The last word carries, in its low 16 bits, the CRC16 of all the words before it. For each event the block recomputes that CRC as the words go past. It gives a pass or fail result on the cycle the closing word is accepted, not afterwards.

Each channel has its own error counter and a sticky error flag. The flag can drive a front-panel lamp. A small register port lets a host read the counters and flags, clear them one channel at a time, and set the select value.

Back-pressure rules:
- All streams use valid/ready. A word moves when valid and ready are both high at a rising clock edge.
- The selected channel's ready is the output's ready.
- Every channel that is not selected is always ready. Its words are checked and then discarded.
- A source must hold its word stable while valid is high and ready is low.

Top module: `evt_crc_passthru`

## Requirements
- R1: The output valid, data, start flag and end flag equal those of the selected input in the same cycle. The selected input's ready equals `out_ready`. While `out_ready` is low, a waiting word is neither consumed nor checked.
- R2: An input that is not selected has `in_ready` held at 1 and is never driven to the output. Its events are still checked.
- R3: The check value uses polynomial 0x1021 and starts from 0xFFFF. Each 32-bit word is fed in bit 31 first. It covers every word of the event except the last one. The last word's bits [15:0] must equal the result.
- R4: `crc_err[i]` is high only during the cycle in which channel i accepts a failing word. At all other times it is low.
- R5: Each error adds one to that channel's counter. The counter stops at 2^CNT_W-1.
- R6: `err_flag[i]` goes high in the cycle after an error on channel i. It stays high until that channel is cleared.
- R7: Writing address 1 with bit i set clears counter i and flag i at the next edge. Other channels are not affected. A clear beats an error that happens in the same cycle.
- R8: A word that carries both the start flag and the end flag is an event with no data words. It counts as an error.
- R9: A start flag that arrives while an event is still open counts as an error on that cycle. That word then begins a new event.
- R10: An end flag that arrives with no event open counts as an error. Words without flags that arrive outside an event are ignored by the checker.
- R11: The register map is as follows.
  - Address 0, bits [SEL_W-1:0]: the select value. A write of a value that is NUM_IN or larger is ignored.
  - Address 1: bit i is flag i.
  - Address 2+i: counter i.
  - Reads are combinational.
- R12: After reset the select value is 0, all counters and flags are 0, and no event is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_IN | Per-channel word valid |
| in_ready | output | NUM_IN | Per-channel word accepted |
| in_data | input | NUM_IN x 32 | Per-channel data word |
| in_sop | input | NUM_IN | Per-channel first-word flag |
| in_eop | input | NUM_IN | Per-channel last-word (check word) flag |
| out_valid | output | 1 | Forwarded word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 32 | Forwarded data word |
| out_sop | output | 1 | Forwarded first-word flag |
| out_eop | output | 1 | Forwarded last-word flag |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Register write strobe, one cycle |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| crc_err | output | NUM_IN | Per-channel error pulse |
| err_flag | output | NUM_IN | Per-channel sticky error indicator |

## Verification
The lane properties treat the start and end flags as meaningful only on accepted words. They also assume that a host clear arrives as a one-cycle write strobe. The select property assumes that register writes are the only way the select value changes.

The stimulus drives each word for exactly one accepted cycle while `out_ready` is high. In the stall case it holds the word stable while ready is low. Only one channel is active at a time, except in the concurrent case, where both channels carry events of equal length side by side.

// File: rtl/evt_crc_pkg.sv
package evt_crc_pkg;
  localparam int WORD_W = 32;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              sop;
    logic              eop;
  } beat_t;

  // Advance the running check value by one word, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_advance(input logic [CRC_W-1:0] c_in,
                                                   input logic [WORD_W-1:0] w);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      fb = c[CRC_W-1] ^ w[b];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/evt_crc_lane.sv
module evt_crc_lane
  import evt_crc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  beat_t            beat,
  input  logic             clr,
  output logic             err_now,
  output logic             sticky_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             open_q, open_d;
  logic [CRC_W-1:0] crc_q, crc_d;

  // Event tracking and the pass/fail decision on the accepted word.
  always_comb begin
    err_now = 1'b0;
    open_d  = open_q;
    crc_d   = crc_q;
    if (fire) begin
      if (beat.sop && beat.eop) begin
        err_now = 1'b1;
        open_d  = 1'b0;
        crc_d   = CRC_SEED;
      end else if (beat.sop) begin
        err_now = open_q;
        open_d  = 1'b1;
        crc_d   = crc_advance(CRC_SEED, beat.data);
      end else if (beat.eop) begin
        err_now = !open_q || (beat.data[CRC_W-1:0] != crc_q);
        open_d  = 1'b0;
        crc_d   = CRC_SEED;
      end else if (open_q) begin
        crc_d = crc_advance(crc_q, beat.data);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      crc_q  <= CRC_SEED;
    end else begin
      open_q <= open_d;
      crc_q  <= crc_d;
    end
  end

  // Saturating counter and sticky flag; clear has priority.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sticky_q <= 1'b0;
    end else if (clr) begin
      cnt_q    <= '0;
      sticky_q <= 1'b0;
    end else if (err_now) begin
      sticky_q <= 1'b1;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |-> !err_now);
  p_empty_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && beat.sop && beat.eop |-> err_now);
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_now && !clr && cnt_q != CNT_MAX |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_MAX && !clr |=> cnt_q == CNT_MAX);
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_now && !clr |=> sticky_q);
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_q && !clr |=> sticky_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0 && !sticky_q);
endmodule

// File: rtl/evt_crc_merge.sv
module evt_crc_merge
  import evt_crc_pkg::*;
#(
  parameter int NUM_IN = 2,
  parameter int SEL_W  = 1
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_IN-1:0] in_valid,
  input  beat_t [NUM_IN-1:0] in_beat,
  output logic [NUM_IN-1:0] in_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output beat_t             out_beat,
  output logic [NUM_IN-1:0] fire
);
  always_comb begin
    out_valid = 1'b0;
    out_beat  = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (sel == SEL_W'(i)) begin
        in_ready[i] = out_ready;
        out_valid   = in_valid[i];
        out_beat    = in_beat[i];
      end else begin
        in_ready[i] = 1'b1;
      end
    end
    fire = in_valid & in_ready;
  end
endmodule

// File: rtl/evt_crc_regs.sv
module evt_crc_regs
  import evt_crc_pkg::*;
#(
  parameter int NUM_IN = 2,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 1,
  parameter int ADDR_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic                          reg_we,
  input  logic [WORD_W-1:0]             reg_wdata,
  input  logic [NUM_IN-1:0]             sticky,
  input  logic [NUM_IN-1:0][CNT_W-1:0]  cnt,
  output logic [SEL_W-1:0]              sel_q,
  output logic [NUM_IN-1:0]             clr,
  output logic [WORD_W-1:0]             reg_rdata
);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(1);

  logic sel_ok;
  assign sel_ok = reg_wdata < WORD_W'(NUM_IN);
  assign clr    = (reg_we && reg_addr == A_FLAG) ? reg_wdata[NUM_IN-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                                   sel_q <= '0;
    else if (reg_we && reg_addr == A_SEL && sel_ok) sel_q <= reg_wdata[SEL_W-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_SEL) reg_rdata[SEL_W-1:0] = sel_q;
    else if (reg_addr == A_FLAG) reg_rdata[NUM_IN-1:0] = sticky;
    for (int i = 0; i < NUM_IN; i++)
      if (reg_addr == ADDR_W'(i + 2)) reg_rdata = WORD_W'(cnt[i]);
  end

  p_sel_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel_q) < NUM_IN);
  p_sel_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == A_SEL && sel_ok |=> sel_q == $past(reg_wdata[SEL_W-1:0]));
endmodule

// File: rtl/evt_crc_passthru.sv
module evt_crc_passthru
  import evt_crc_pkg::*;
#(
  parameter int NUM_IN = 2,
  parameter int CNT_W  = 16,
  localparam int SEL_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int ADDR_W = $clog2(NUM_IN + 2)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_IN-1:0]              in_valid,
  output logic [NUM_IN-1:0]              in_ready,
  input  logic [NUM_IN-1:0][WORD_W-1:0]  in_data,
  input  logic [NUM_IN-1:0]              in_sop,
  input  logic [NUM_IN-1:0]              in_eop,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [WORD_W-1:0]              out_data,
  output logic                           out_sop,
  output logic                           out_eop,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic                           reg_we,
  input  logic [WORD_W-1:0]              reg_wdata,
  output logic [WORD_W-1:0]              reg_rdata,
  output logic [NUM_IN-1:0]              crc_err,
  output logic [NUM_IN-1:0]              err_flag
);
  beat_t [NUM_IN-1:0]             beats;
  beat_t                          out_beat;
  logic  [NUM_IN-1:0]             fire;
  logic  [NUM_IN-1:0]             clr;
  logic  [SEL_W-1:0]              sel;
  logic  [NUM_IN-1:0][CNT_W-1:0]  cnt;

  always_comb
    for (int i = 0; i < NUM_IN; i++) beats[i] = '{data: in_data[i], sop: in_sop[i], eop: in_eop[i]};

  evt_crc_merge #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_merge (
    .sel(sel), .in_valid(in_valid), .in_beat(beats), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid), .out_beat(out_beat), .fire(fire)
  );

  assign out_data = out_beat.data;
  assign out_sop  = out_beat.sop;
  assign out_eop  = out_beat.eop;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    evt_crc_lane #(.CNT_W(CNT_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .fire(fire[g]), .beat(beats[g]), .clr(clr[g]),
      .err_now(crc_err[g]), .sticky_q(err_flag[g]), .cnt_q(cnt[g])
    );
  end

  evt_crc_regs #(.NUM_IN(NUM_IN), .CNT_W(CNT_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .sticky(err_flag), .cnt(cnt), .sel_q(sel), .clr(clr), .reg_rdata(reg_rdata)
  );
endmodule

// File: tb/evt_crc_passthru_bench.sv
module evt_crc_passthru_bench;
  localparam int CNTW = 4;
  localparam int SATV = 15;

  logic clk = 0, rst_n = 0;
  logic [1:0] in_valid = '0, in_sop = '0, in_eop = '0, in_ready;
  logic [1:0][31:0] in_data = '0;
  logic out_valid, out_sop, out_eop, out_ready = 1;
  logic [31:0] out_data, reg_rdata, reg_wdata = '0;
  logic [1:0] reg_addr = '0, crc_err, err_flag;
  logic reg_we = 0;

  int total = 0, bad = 0, cur_sel = 0;
  int expcnt [2] = '{0, 0};

  always #10 clk = ~clk;

  evt_crc_passthru #(.NUM_IN(2), .CNT_W(CNTW)) u_evt_crc_passthru (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sop, .in_eop,
    .out_valid, .out_ready, .out_data, .out_sop, .out_eop,
    .reg_addr, .reg_we, .reg_wdata, .reg_rdata, .crc_err, .err_flag);

  // fields: chan[14], data words[13:10], seed[9:2], corrupt[1], forward[0]
  localparam logic [14:0] VEC [9] = '{
    {1'b0, 4'd3,  8'h11, 1'b0, 1'b1}, {1'b0, 4'd5,  8'h22, 1'b1, 1'b1},
    {1'b1, 4'd1,  8'h33, 1'b0, 1'b0}, {1'b1, 4'd4,  8'h44, 1'b1, 1'b0},
    {1'b0, 4'd0,  8'h55, 1'b0, 1'b1}, {1'b1, 4'd7,  8'h66, 1'b0, 1'b1},
    {1'b0, 4'd15, 8'h77, 1'b0, 1'b0}, {1'b1, 4'd2,  8'h88, 1'b1, 1'b1},
    {1'b0, 4'd1,  8'h99, 1'b1, 1'b1}};

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] r = c;
    for (int k = 0; k < 32; k++) begin
      logic top = r[15] ^ w[31-k];
      r = r << 1;
      if (top) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [31:0] mkw(input logic [7:0] s, input int k);
    return {s, 8'(k), s ^ 8'hA5, 8'(k * 3)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); reg_addr = a; #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic idle();
    @(negedge clk); in_valid = '0; in_sop = '0; in_eop = '0;
  endtask

  function automatic void bump(input int ch);
    if (expcnt[ch] < SATV) expcnt[ch]++;
  endfunction

  task automatic send_word(input int ch, input logic [31:0] d, input bit s, input bit e, input bit exp_err);
    @(negedge clk);
    in_valid = '0; in_sop = '0; in_eop = '0;
    in_valid[ch] = 1; in_data[ch] = d; in_sop[ch] = s; in_eop[ch] = e;
    #1;
    if (ch == cur_sel)
      check(out_valid && out_data == d && out_sop == s && out_eop == e, "R1 passthrough", out_data, d);
    else
      check(in_ready[ch] && !out_valid, "R2 unselected sink", {30'd0, out_valid, in_ready[ch]}, 32'd1);
    check(crc_err == (exp_err ? 2'(1 << ch) : 2'b00), "R4 error pulse", 32'(crc_err), exp_err ? 32'(1 << ch) : 0);
    if (exp_err) bump(ch);
  endtask

  task automatic send_event(input int ch, input int len, input logic [7:0] seed, input bit corrupt);
    logic [15:0] c = 16'hFFFF;
    bit exp_err = corrupt || len == 0;
    for (int k = 0; k < len; k++) begin
      send_word(ch, mkw(seed, k), k == 0, 0, 0);
      c = ref_crc(c, mkw(seed, k));
    end
    if (len == 0) send_word(ch, 32'h0000FFFF, 1, 1, 1);
    else          send_word(ch, {16'hC0DE, c ^ 16'(corrupt)}, 0, 1, exp_err);
    idle();
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state
    rd_chk(0, 0, "R12 select"); rd_chk(1, 0, "R12 flags");
    rd_chk(2, 0, "R12 count0"); rd_chk(3, 0, "R12 count1");
    check(!out_valid && crc_err == 0 && in_ready[1], "R12 outputs", {29'd0, out_valid, crc_err}, 0);

    // Table walk: R3 check value, R1/R2 routing, R8 empty event
    foreach (VEC[v]) begin
      int ch = int'(VEC[v][14]);
      cur_sel = VEC[v][0] ? ch : 1 - ch;
      wr(0, 32'(cur_sel));
      send_event(ch, int'(VEC[v][13:10]), VEC[v][9:2], VEC[v][1]);
      rd_chk(2'(2 + ch), 32'(expcnt[ch]), "R3 R5 count after event");
      rd_chk(1, {30'd0, expcnt[1] > 0, expcnt[0] > 0}, "R6 flags after event");
    end

    // R7 clear both
    wr(1, 3); expcnt = '{0, 0};
    rd_chk(1, 0, "R7 flags cleared"); rd_chk(2, 0, "R7 count0 cleared"); rd_chk(3, 0, "R7 count1 cleared");

    // R5 saturation on channel 0
    cur_sel = 0; wr(0, 0);
    for (int n = 0; n < 20; n++) send_word(0, 32'h1234, 0, 1, 1);
    idle();
    rd_chk(2, SATV, "R5 saturated");
    send_word(1, 32'h5678, 0, 1, 1); idle();

    // R7 clear one channel only
    wr(1, 1);
    rd_chk(2, 0, "R7 count0 cleared alone"); rd_chk(3, 1, "R7 count1 kept");
    rd_chk(1, 2, "R7 flag1 kept");

    // R7 clear beats a same-cycle error
    @(negedge clk);
    in_valid[1] = 1; in_eop[1] = 1; in_sop[1] = 0; in_data[1] = 32'h9;
    reg_addr = 1; reg_wdata = 2; reg_we = 1; #1;
    check(crc_err == 2'b10, "R7 error raised during clear", 32'(crc_err), 2);
    @(negedge clk); reg_we = 0; in_valid = '0; in_eop = '0;
    rd_chk(3, 0, "R7 clear wins count"); rd_chk(1, 0, "R7 clear wins flag");
    expcnt = '{0, 0};

    // R9 start while open aborts and restarts
    begin
      logic [15:0] c;
      send_word(0, 32'hA0A0_0001, 1, 0, 0);
      send_word(0, 32'hA0A0_0002, 0, 0, 0);
      send_word(0, 32'hB0B0_0001, 1, 0, 1);
      send_word(0, 32'hB0B0_0002, 0, 0, 0);
      c = ref_crc(ref_crc(16'hFFFF, 32'hB0B0_0001), 32'hB0B0_0002);
      send_word(0, {16'h0, c}, 0, 1, 0);
      idle();
      rd_chk(2, 1, "R9 abort counted once");
    end

    // R10 stray word ignored, orphan end counted
    send_word(1, 32'hDEAD_BEEF, 0, 0, 0);
    send_word(1, 32'h0000_FFFF, 0, 1, 1);
    idle();
    send_event(1, 2, 8'h3C, 0);
    rd_chk(3, 1, "R10 orphan counted");

    // R1 stall: word waits, not consumed, CRC not advanced
    begin
      logic [31:0] w0 = 32'hCAFE_0001;
      @(negedge clk); out_ready = 0;
      in_valid[0] = 1; in_sop[0] = 1; in_eop[0] = 0; in_data[0] = w0;
      repeat (3) begin
        #1; check(!in_ready[0] && out_valid && out_data == w0, "R1 stall holds", out_data, w0);
        @(negedge clk);
      end
      out_ready = 1;
      send_word(0, {16'h0, ref_crc(16'hFFFF, w0)}, 0, 1, 0);
      idle();
      rd_chk(2, 1, "R1 stall no extra error");
    end

    // R2 both channels at once, only selected forwarded, both checked
    wr(1, 3); expcnt = '{0, 0};
    begin
      logic [15:0] c0 = 16'hFFFF, c1 = 16'hFFFF;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        in_valid = 2'b11; in_sop = {2{k == 0}}; in_eop = 0;
        in_data[0] = mkw(8'h0F, k); in_data[1] = mkw(8'hF0, k);
        c0 = ref_crc(c0, mkw(8'h0F, k)); c1 = ref_crc(c1, mkw(8'hF0, k));
        #1; check(out_data == mkw(8'h0F, k) && in_ready == 2'b11, "R2 only selected forwarded", out_data, mkw(8'h0F, k));
      end
      @(negedge clk);
      in_sop = 0; in_eop = 2'b11;
      in_data[0] = {16'h0, c0}; in_data[1] = {16'h0, c1 ^ 16'h8000};
      #1; check(crc_err == 2'b10, "R2 unselected channel checked", 32'(crc_err), 2);
      idle();
      rd_chk(2, 0, "R2 count0"); rd_chk(3, 1, "R2 count1");
    end

    // R11 illegal select write ignored
    wr(0, 1); wr(0, 2);
    rd_chk(0, 1, "R11 illegal select ignored");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule